// File: doc/BRIEF.md
# Auxiliary Memory Bank Address Mapper

This block turns a 16-bit processor address, together with the current banking switch state, into a physical destination. The destination is one of main RAM, auxiliary RAM, system ROM, peripheral card ROM, the I/O space, or nothing at all. The block also gives the byte offset inside that destination and a memory write strobe. It is purely combinational, so all three outputs follow the address and flags in the same cycle. The memory arrays and the I/O devices sit outside the block.

Read and write accesses are routed separately. This lets a program execute from one RAM bank while it stores into the other. Where address regions overlap, a fixed precedence resolves them. The slot ROM overlays and the I/O page take priority over the generic peripheral ROM window. The display text page can be steered by the page-select switch, and this override is stronger than the general read and write bank switches. The language-card area at the top of memory is controlled by three signals: a read-source select, a write enable and a bank select. Its first 4 KiB can be redirected to a second bank.

Top module: `aux_bank_mapper`

## Requirements
- R1: For 0x0000–0x01FF, reads and writes target auxiliary RAM (code 2) when `zp_aux` is 1 and main RAM (code 1) when it is 0, with offset equal to the address.
- R2: For 0x0200–0xBFFF outside the text and hi-res pages, a read targets auxiliary RAM when `rd_aux` is 1, and a write targets auxiliary RAM when `wr_aux` is 1. Otherwise the target is main RAM. The offset equals the address.
- R3: For 0x0400–0x07FF with `store80` at 1, `page_sel` alone picks auxiliary (1) or main (0) for both reads and writes. With `store80` at 0, the page follows R2.
- R4: For 0x2000–0x3FFF the target follows `rd_aux`/`wr_aux` as in R2, whatever the values of `store80` and `page_sel`.
- R5: For 0xC000–0xC0FF the target is I/O (code 5), the offset is the address's low 8 bits, and `mem_we` is 0. This holds for both reads and writes.
- R6: Reads in 0xC100–0xCFFF not covered by R7/R8 target system ROM (code 3) at offset equal to the address. Writes anywhere in 0xC100–0xCFFF give target none (code 0), offset equal to the address, and `mem_we` 0.
- R7: Reads in 0xC300–0xC3FF target system ROM. The offset is the address's low 8 bits when `c3_rom_int` is 1, and the full address when it is 0.
- R8: Reads in 0xC600–0xC6FF target peripheral ROM (code 4) at offset of the low 8 bits when `cx_rom_int` is 1. When it is 0 they target system ROM at the full address.
- R9: Reads in 0xD000–0xFFFF target system ROM at the full address when `lc_rd_ram` is 0. When it is 1 they target RAM, which is auxiliary if `zp_aux` is 1 and main otherwise.
- R10: A RAM access in 0xD000–0xDFFF with `lc_bank2` at 0 uses offset address − 0x1000. With `lc_bank2` at 1, or anywhere in 0xE000–0xFFFF, the offset is the address.
- R11: Writes in 0xD000–0xFFFF with `lc_wr_en` at 1 target RAM (auxiliary if `zp_aux`), with `mem_we` at 1. With `lc_wr_en` at 0 the write is dropped: target none, offset equal to the address, `mem_we` at 0.
- R12: `mem_we` is 1 exactly when `wr` is 1 and the target is main or auxiliary RAM. Reads never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address |
| wr | input | 1 | 1 for a write access, 0 for a read |
| zp_aux | input | 1 | Page zero/stack and language-card RAM in auxiliary bank |
| rd_aux | input | 1 | Reads of general RAM from auxiliary bank |
| wr_aux | input | 1 | Writes of general RAM to auxiliary bank |
| store80 | input | 1 | Text page follows `page_sel` |
| page_sel | input | 1 | Page select used by the text override |
| cx_rom_int | input | 1 | 0xC6xx reads come from peripheral ROM |
| c3_rom_int | input | 1 | 0xC3xx reads come from system ROM offset 0 |
| lc_rd_ram | input | 1 | Language-card reads from RAM instead of ROM |
| lc_wr_en | input | 1 | Language-card RAM writable |
| lc_bank2 | input | 1 | Language-card 4 KiB window uses bank 2 |
| target | output | 3 | 0 none, 1 main, 2 aux, 3 system ROM, 4 peripheral ROM, 5 I/O |
| phys_off | output | 16 | Byte offset inside the target |
| mem_we | output | 1 | Write strobe to the selected RAM |

## Verification
Two routing rules can apply to one access in the same cycle. The text-page override can meet a disagreement between `rd_aux` and `wr_aux`, and the bank-1 offset redirect can meet the auxiliary selection from `zp_aux`. Directed cases provoke both pairs by writing and reading the text page with `store80` set while the two bank switches differ, and by accessing 0xD000–0xDFFF with `lc_bank2` clear and `zp_aux` set. A random sweep then mixes every flag with every region. A behavioural model judges every case by comparing target, offset and strobe together. That model checks address ranges from the most specific to the most general.

// File: rtl/amap_pkg.sv
// Shared types and constants for the auxiliary bank mapper.
// Assumes a 16-bit processor address space.
package amap_pkg;
    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_MAIN   = 3'd1,
        TGT_AUX    = 3'd2,
        TGT_SYSROM = 3'd3,
        TGT_PERIPH = 3'd4,
        TGT_IO     = 3'd5
    } tgt_e;

    typedef enum logic [3:0] {
        RG_ZP,
        RG_GEN,
        RG_TEXT,
        RG_HIRES,
        RG_IO,
        RG_SLOT,
        RG_C3,
        RG_C6,
        RG_LCB,
        RG_UPPER
    } region_e;

    localparam int unsigned AW = 16;
    localparam logic [AW-1:0] ZP_END     = 16'h01FF;
    localparam logic [AW-1:0] TEXT_LO    = 16'h0400;
    localparam logic [AW-1:0] TEXT_HI    = 16'h07FF;
    localparam logic [AW-1:0] HIRES_LO   = 16'h2000;
    localparam logic [AW-1:0] HIRES_HI   = 16'h3FFF;
    localparam logic [AW-1:0] IO_LO      = 16'hC000;
    localparam logic [AW-1:0] IO_HI      = 16'hC0FF;
    localparam logic [AW-1:0] SLOT_HI    = 16'hCFFF;
    localparam logic [AW-1:0] C3_LO      = 16'hC300;
    localparam logic [AW-1:0] C3_HI      = 16'hC3FF;
    localparam logic [AW-1:0] C6_LO      = 16'hC600;
    localparam logic [AW-1:0] C6_HI      = 16'hC6FF;
    localparam logic [AW-1:0] LCB_HI     = 16'hDFFF;
    localparam logic [AW-1:0] BANK1_DIFF = 16'h1000;
endpackage

// File: rtl/amap_region_dec.sv
// Region decoder: classifies an address into one region, resolving
// overlaps by fixed precedence (slot overlays and I/O before the slot
// window, text/hi-res pages before general RAM).
module amap_region_dec
    import amap_pkg::*;
#(
    parameter int unsigned ADDR_W = AW
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    // Priority classification from most specific to most general.
    always_comb begin
        if (addr >= C6_LO && addr <= C6_HI)            region = RG_C6;
        else if (addr >= C3_LO && addr <= C3_HI)       region = RG_C3;
        else if (addr >= IO_LO && addr <= IO_HI)       region = RG_IO;
        else if (addr > IO_HI && addr <= SLOT_HI)      region = RG_SLOT;
        else if (addr > SLOT_HI && addr <= LCB_HI)     region = RG_LCB;
        else if (addr > LCB_HI)                        region = RG_UPPER;
        else if (addr <= ZP_END)                       region = RG_ZP;
        else if (addr >= TEXT_LO && addr <= TEXT_HI)   region = RG_TEXT;
        else if (addr >= HIRES_LO && addr <= HIRES_HI) region = RG_HIRES;
        else                                           region = RG_GEN;
    end
endmodule

// File: rtl/amap_ram_sel.sv
// RAM bank selector: decides whether an access lands in RAM and, if so,
// which bank. Read and write bank choices are made independently.
module amap_ram_sel
    import amap_pkg::*;
(
    input  region_e region,
    input  logic    wr,
    input  logic    zp_aux,
    input  logic    rd_aux,
    input  logic    wr_aux,
    input  logic    store80,
    input  logic    page_sel,
    input  logic    lc_rd_ram,
    input  logic    lc_wr_en,
    input  logic    lc_bank2,
    output logic    ram_hit,
    output logic    use_aux,
    output logic    bank1_shift
);
    logic gen_aux;

    // Bank picked by the general read/write switches for this direction.
    always_comb gen_aux = wr ? wr_aux : rd_aux;

    // Per-region RAM hit and bank selection.
    always_comb begin
        ram_hit     = 1'b0;
        use_aux     = 1'b0;
        bank1_shift = 1'b0;
        unique case (region)
            RG_ZP: begin
                ram_hit = 1'b1;
                use_aux = zp_aux;
            end
            RG_TEXT: begin
                ram_hit = 1'b1;
                use_aux = store80 ? page_sel : gen_aux;
            end
            RG_HIRES, RG_GEN: begin
                ram_hit = 1'b1;
                use_aux = gen_aux;
            end
            RG_LCB, RG_UPPER: begin
                ram_hit     = wr ? lc_wr_en : lc_rd_ram;
                use_aux     = zp_aux;
                bank1_shift = (region == RG_LCB) && !lc_bank2;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amap_rom_sel.sv
// ROM selector: routes reads of the ROM-backed regions to system or
// peripheral ROM and computes the ROM offset. Writes never hit ROM.
module amap_rom_sel
    import amap_pkg::*;
#(
    parameter int unsigned ADDR_W = AW
) (
    input  region_e           region,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              cx_rom_int,
    input  logic              c3_rom_int,
    input  logic              lc_rd_ram,
    output logic              rom_hit,
    output tgt_e              rom_tgt,
    output logic [ADDR_W-1:0] rom_off
);
    localparam int unsigned PAGE_W = 8;
    logic [ADDR_W-1:0] low_page;

    // Offset within a 256-byte page.
    always_comb low_page = {{(ADDR_W-PAGE_W){1'b0}}, addr[PAGE_W-1:0]};

    // ROM source and offset for read accesses.
    always_comb begin
        rom_hit = 1'b0;
        rom_tgt = TGT_SYSROM;
        rom_off = addr;
        if (!wr) begin
            unique case (region)
                RG_SLOT: rom_hit = 1'b1;
                RG_C3: begin
                    rom_hit = 1'b1;
                    if (c3_rom_int) rom_off = low_page;
                end
                RG_C6: begin
                    rom_hit = 1'b1;
                    if (cx_rom_int) begin
                        rom_tgt = TGT_PERIPH;
                        rom_off = low_page;
                    end
                end
                RG_LCB, RG_UPPER: rom_hit = !lc_rd_ram;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aux_bank_mapper.sv
// Top of the auxiliary bank mapper. Combinational: target, offset and
// write strobe follow the address and switch inputs in the same cycle.
// Assumes the caller qualifies mem_we with its own bus cycle timing.
module aux_bank_mapper
    import amap_pkg::*;
#(
    parameter int unsigned ADDR_W = AW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              zp_aux,
    input  logic              rd_aux,
    input  logic              wr_aux,
    input  logic              store80,
    input  logic              page_sel,
    input  logic              cx_rom_int,
    input  logic              c3_rom_int,
    input  logic              lc_rd_ram,
    input  logic              lc_wr_en,
    input  logic              lc_bank2,
    output logic [2:0]        target,
    output logic [ADDR_W-1:0] phys_off,
    output logic              mem_we
);
    localparam int unsigned PAGE_W = 8;

    region_e           region;
    logic              ram_hit, use_aux, bank1_shift;
    logic              rom_hit;
    tgt_e              rom_tgt;
    logic [ADDR_W-1:0] rom_off;
    tgt_e              tgt;

    amap_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .region (region)
    );

    amap_ram_sel u_ram (
        .region      (region),
        .wr          (wr),
        .zp_aux      (zp_aux),
        .rd_aux      (rd_aux),
        .wr_aux      (wr_aux),
        .store80     (store80),
        .page_sel    (page_sel),
        .lc_rd_ram   (lc_rd_ram),
        .lc_wr_en    (lc_wr_en),
        .lc_bank2    (lc_bank2),
        .ram_hit     (ram_hit),
        .use_aux     (use_aux),
        .bank1_shift (bank1_shift)
    );

    amap_rom_sel #(.ADDR_W(ADDR_W)) u_rom (
        .region     (region),
        .addr       (addr),
        .wr         (wr),
        .cx_rom_int (cx_rom_int),
        .c3_rom_int (c3_rom_int),
        .lc_rd_ram  (lc_rd_ram),
        .rom_hit    (rom_hit),
        .rom_tgt    (rom_tgt),
        .rom_off    (rom_off)
    );

    // Merge: I/O first, then RAM, then ROM, otherwise drop the access.
    always_comb begin
        tgt      = TGT_NONE;
        phys_off = addr;
        mem_we   = 1'b0;
        if (region == RG_IO) begin
            tgt      = TGT_IO;
            phys_off = {{(ADDR_W-PAGE_W){1'b0}}, addr[PAGE_W-1:0]};
        end else if (ram_hit) begin
            tgt      = use_aux ? TGT_AUX : TGT_MAIN;
            phys_off = bank1_shift ? (addr - BANK1_DIFF) : addr;
            mem_we   = wr;
        end else if (rom_hit) begin
            tgt      = rom_tgt;
            phys_off = rom_off;
        end
    end

    always_comb target = tgt;

    // Cross-checks between decoder, selectors and merged outputs.
    always_comb begin
        a_r12_we_only_ram_write: assert (!mem_we || (wr && (tgt == TGT_MAIN || tgt == TGT_AUX)))
            else $error("R12: write strobe without RAM write");
        a_r5_io_no_we: assert (region != RG_IO || (tgt == TGT_IO && !mem_we))
            else $error("R5: I/O page produced memory access");
        a_r6_rom_write_dropped: assert (!(wr && (region == RG_SLOT || region == RG_C3 || region == RG_C6)) || tgt == TGT_NONE)
            else $error("R6: write into ROM window not dropped");
        a_r3_text_override: assert (!(region == RG_TEXT && store80) || ((tgt == TGT_AUX) == page_sel))
            else $error("R3: text page ignored page select");
        a_r1_zp_bank: assert (region != RG_ZP || ((tgt == TGT_AUX) == zp_aux))
            else $error("R1: page zero bank mismatch");
        a_r11_lc_write_block: assert (!(wr && !lc_wr_en && (region == RG_LCB || region == RG_UPPER)) || !mem_we)
            else $error("R11: blocked language-card write strobed");
    end
endmodule

// File: tb/test_aux_bank_mapper.sv
`timescale 1ns/1ps
module test_aux_bank_mapper;
    localparam real CLK_NS = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        zp_aux = 0, rd_aux = 0, wr_aux = 0, store80 = 0, page_sel = 0;
    logic        cx_rom_int = 0, c3_rom_int = 0, lc_rd_ram = 0, lc_wr_en = 0, lc_bank2 = 0;
    logic [2:0]  target;
    logic [15:0] phys_off;
    logic        mem_we;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    aux_bank_mapper i_aux_bank_mapper (
        .addr(addr), .wr(wr), .zp_aux(zp_aux), .rd_aux(rd_aux), .wr_aux(wr_aux),
        .store80(store80), .page_sel(page_sel), .cx_rom_int(cx_rom_int),
        .c3_rom_int(c3_rom_int), .lc_rd_ram(lc_rd_ram), .lc_wr_en(lc_wr_en),
        .lc_bank2(lc_bank2), .target(target), .phys_off(phys_off), .mem_we(mem_we)
    );

    // Behavioural reference: checks address ranges as integers.
    task automatic model(output int t, output int off, output int we, output string req);
        int a = int'(addr);
        bit ramsel;
        t = 0; off = a; we = 0; req = "R2";
        if (a >= 'hC000 && a <= 'hC0FF) begin
            t = 5; off = a % 256; req = "R5";
        end else if (a >= 'hC100 && a <= 'hCFFF) begin
            if (wr) begin t = 0; req = "R6"; end
            else if (a >= 'hC600 && a <= 'hC6FF) begin
                req = "R8";
                if (cx_rom_int) begin t = 4; off = a % 256; end else t = 3;
            end else if (a >= 'hC300 && a <= 'hC3FF) begin
                req = "R7"; t = 3;
                if (c3_rom_int) off = a % 256;
            end else begin t = 3; req = "R6"; end
        end else if (a >= 'hD000) begin
            ramsel = wr ? lc_wr_en : lc_rd_ram;
            req = wr ? "R11" : "R9";
            if (ramsel) begin
                t = zp_aux ? 2 : 1;
                if (a < 'hE000 && !lc_bank2) begin off = a - 4096; req = "R10"; end
                we = wr;
            end else t = wr ? 0 : 3;
        end else if (a < 'h0200) begin
            t = zp_aux ? 2 : 1; we = wr; req = "R1";
        end else begin
            if (a >= 'h0400 && a <= 'h07FF && store80) begin
                t = page_sel ? 2 : 1; req = "R3";
            end else begin
                t = (wr ? wr_aux : rd_aux) ? 2 : 1;
                if (a >= 'h2000 && a <= 'h3FFF) req = "R4";
            end
            we = wr;
        end
    endtask

    task automatic check_now();
        int et, eo, ew;
        string req;
        model(et, eo, ew, req);
        compared++;
        if (int'(target) != et || int'(phys_off) != eo || int'(mem_we) != ew) begin
            mismatched++;
            $display("FAIL %s addr=%h wr=%0d: got tgt=%0d off=%h we=%0d, expected tgt=%0d off=%h we=%0d (R12 strobe)",
                     req, addr, wr, target, phys_off, mem_we, et, eo[15:0], ew);
        end
    endtask

    // Drive on rising edge, compare at falling edge.
    task automatic apply(input logic [15:0] a, input logic w, input logic [9:0] f);
        @(posedge clk);
        addr = a; wr = w;
        {zp_aux, rd_aux, wr_aux, store80, page_sel, cx_rom_int, c3_rom_int,
         lc_rd_ram, lc_wr_en, lc_bank2} = f;
        @(negedge clk);
        check_now();
    endtask

    // Flag vector order: zp_aux rd_aux wr_aux store80 page_sel cx c3 lcrd lcwe bank2
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now();                                  // reset state: R1 main, offset 0
        apply(16'h0100, 1, 10'b1000000000);           // R1 aux write
        apply(16'h01FF, 0, 10'b0110000000);           // R1 main despite rd_aux
        apply(16'h8000, 0, 10'b0100000000);           // R2 read aux
        apply(16'h8000, 1, 10'b0100000000);           // R2 write main
        apply(16'h0500, 1, 10'b0101100000);           // R3 text override vs wr/rd split
        apply(16'h0500, 0, 10'b0101000000);           // R3 page 0 beats rd_aux
        apply(16'h0500, 1, 10'b0010000000);           // R3 no store80 -> wr_aux
        apply(16'h2400, 0, 10'b0001100000);           // R4 hi-res ignores page
        apply(16'h3FFF, 1, 10'b0011100000);           // R4 write aux
        apply(16'hC030, 1, 10'b1111111111);           // R5 io write
        apply(16'hC0FF, 0, 10'b0000000000);           // R5 io read
        apply(16'hC100, 0, 10'b0000000000);           // R6 slot rom read
        apply(16'hCFFF, 1, 10'b0000000000);           // R6 rom write dropped
        apply(16'hC380, 0, 10'b0000001000);           // R7 internal
        apply(16'hC380, 0, 10'b0000000000);           // R7 slot
        apply(16'hC6AA, 0, 10'b0000010000);           // R8 peripheral
        apply(16'hC6AA, 0, 10'b0000000000);           // R8 system rom
        apply(16'hE123, 0, 10'b0000000000);           // R9 rom read
        apply(16'hD234, 0, 10'b1000000100);           // R10 bank1 + aux
        apply(16'hD234, 1, 10'b1000000010);           // R10 bank1 write aux
        apply(16'hD234, 0, 10'b0000000101);           // R10 bank2
        apply(16'hFFFF, 1, 10'b0000000000);           // R11 blocked write
        apply(16'hF000, 1, 10'b1000000010);           // R11 enabled write
        for (int i = 0; i < 4000; i++) begin
            apply(16'($urandom), 1'($urandom), 10'($urandom));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run hung (actual running, expected finished)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule